// File: doc/BRIEF.md
# Redundant Scan-Reuse Flip-Flop Chain

This block models a row of hardened flip-flops in which the scan shadow of each cell, normally idle in mission operation, is reused as a second copy of the stored bit. Every cell has a system half and a scan half. The system half is a master stage and a slave stage driven by the functional clock level. The scan half is a first and a second stage moved by two alternating scan strobes. A merge stage combines the system slave with the scan second stage. When the two copies agree, the merge stage passes the value to the output. When they disagree, it keeps its previous output, so a single upset in any stored stage is masked.

Static control levels put the row in one of three modes. In normal mode the scan half samples the data input alongside the system half, and correction is active. In test mode the scan half is free for shift, update and capture, and the output is driven by the system half alone. Economy mode parks the scan half, with a closed first stage and an open second stage, so it stops switching, and the output again follows the system half only. Cell 0 takes the chain scan input, each cell feeds the next, and the last cell's second scan stage is the chain scan output.

The model runs on one fast reference clock. The functional clock and the scan strobes are level inputs sampled on each reference edge, and each stage is a register enabled by its own control. Per-stage upset inputs invert a chosen stage for one reference cycle so that correction can be exercised.

Top module: `rsr_chain`

## Requirements
- R1: A synchronous active-high reset clears every stage of every cell, the outputs `q` and the scan output `so` to 0.
- R2: In normal mode (`test`=0, `capture`=1, `scan_a`=`scan_b`=`update`=0), one reference cycle with `fclk`=1 followed by two with `fclk`=0 makes `q` equal the value held on `d`.
- R3: In normal mode, inverting one stored stage of a cell (system master, system slave or scan second stage) leaves that cell's `q` unchanged for as long as the two copies disagree.
- R4: After an upset, the next complete normal capture (one `fclk`=1 cycle, two `fclk`=0 cycles) brings the copies back into agreement and `q` takes the new `d`.
- R5: With `test`=1, `q` equals the system slave one reference cycle later, whatever the scan second stage holds.
- R6: A reference cycle with `scan_a`=1 loads each cell's first scan stage from its scan input (chain `si` for cell 0, the previous cell's second scan stage otherwise). A following cycle with `scan_b`=1 copies the first scan stage into the second. `so` is the second scan stage of the last cell, and the first bit shifted in ends in the last cell.
- R7: A reference cycle with `update`=1 loads the system master from the second scan stage, ahead of any data load.
- R8: In test mode, a reference cycle with `capture`=1 copies the system master into the first scan stage.
- R9: In economy mode (`test`=1, `capture`=0, `scan_a`=0, `scan_b`=1), the scan stages keep their contents through functional captures while `q` follows `d` through the system half.
- R10: A high bit on `upset_m`, `upset_s`, `upset_a` or `upset_b` inverts that stage of that cell at the next reference edge, taking priority over any load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fclk | input | 1 | Functional clock level; 1 opens the masters, 0 opens the slaves |
| scan_a | input | 1 | First scan strobe, loads first scan stages from scan input |
| scan_b | input | 1 | Second scan strobe, opens second scan stages |
| update | input | 1 | Copies second scan stage into system master |
| capture | input | 1 | Normal mode: scan first stage samples `d` while `fclk`=1; test mode: copies system master into it |
| test | input | 1 | Static level; 1 removes the scan copy from the output |
| d | input | N_CELLS | Data inputs, one per cell |
| si | input | 1 | Chain scan input to cell 0 |
| upset_m | input | N_CELLS | Upset injection into system masters |
| upset_s | input | N_CELLS | Upset injection into system slaves |
| upset_a | input | N_CELLS | Upset injection into first scan stages |
| upset_b | input | N_CELLS | Upset injection into second scan stages |
| q | output | N_CELLS | Registered merged outputs |
| so | output | 1 | Chain scan output (last cell second scan stage) |

## Verification
The properties assume the mode levels are set up one reference cycle before a sequence that depends on them. They also assume that `scan_a` and `scan_b` are never high in the same cycle, and that `update` is only used in test mode. The stimulus raises at most one upset bit per cell at a time and never during a shift. It holds `fclk` high through every scan shift, so the second scan stages move only on `scan_b`. For update and capture it lowers `fclk` in the same cycle as the strobe, so a later data load cannot overwrite the strobed value before it is observed.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  typedef struct packed {
    logic mst;
    logic slv;
    logic sca;
    logic scb;
  } rsr_state_t;

  localparam rsr_state_t RSR_STATE_RST = '{mst: 1'b0, slv: 1'b0, sca: 1'b0, scb: 1'b0};
endpackage

// File: rtl/rsr_sys_half.sv
module rsr_sys_half (
  input  logic clk,
  input  logic rst,
  input  logic fclk,
  input  logic update,
  input  logic d,
  input  logic scan_b_val,
  input  logic up_m,
  input  logic up_s,
  output logic mst,
  output logic slv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mst <= 1'b0;
    end else if (up_m) begin
      mst <= ~mst;
    end else if (update) begin
      mst <= scan_b_val;
    end else if (fclk) begin
      mst <= d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slv <= 1'b0;
    end else if (up_s) begin
      slv <= ~slv;
    end else if (!fclk) begin
      slv <= mst;
    end
  end
endmodule

// File: rtl/rsr_scan_half.sv
module rsr_scan_half (
  input  logic clk,
  input  logic rst,
  input  logic fclk,
  input  logic scan_a,
  input  logic scan_b,
  input  logic capture,
  input  logic test,
  input  logic d,
  input  logic sin,
  input  logic sys_mst,
  input  logic up_a,
  input  logic up_b,
  output logic sca,
  output logic scb
);
  logic load_scan;
  logic load_resp;
  logic load_data;
  logic open_b;

  always_comb begin
    load_scan = scan_a;
    load_resp = capture && test;
    load_data = capture && !test && fclk;
    open_b    = scan_b || !fclk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sca <= 1'b0;
    end else if (up_a) begin
      sca <= ~sca;
    end else if (load_scan) begin
      sca <= sin;
    end else if (load_resp) begin
      sca <= sys_mst;
    end else if (load_data) begin
      sca <= d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scb <= 1'b0;
    end else if (up_b) begin
      scb <= ~scb;
    end else if (open_b) begin
      scb <= sca;
    end
  end
endmodule

// File: rtl/rsr_merge.sv
module rsr_merge (
  input  logic clk,
  input  logic rst,
  input  logic test,
  input  logic copy_sys,
  input  logic copy_scan,
  output logic q
);
  logic agree;

  always_comb agree = (copy_sys == copy_scan);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (test || agree) begin
      q <= copy_sys;
    end
  end
endmodule

// File: rtl/rsr_cell.sv
module rsr_cell
  import rsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fclk,
  input  logic       scan_a,
  input  logic       scan_b,
  input  logic       update,
  input  logic       capture,
  input  logic       test,
  input  logic       d,
  input  logic       sin,
  input  logic [3:0] upset,
  output logic       q,
  output rsr_state_t st
);
  logic mst, slv, sca, scb;

  rsr_sys_half u_sys (
    .clk(clk), .rst(rst), .fclk(fclk), .update(update), .d(d),
    .scan_b_val(scb), .up_m(upset[3]), .up_s(upset[2]),
    .mst(mst), .slv(slv)
  );

  rsr_scan_half u_scan (
    .clk(clk), .rst(rst), .fclk(fclk), .scan_a(scan_a), .scan_b(scan_b),
    .capture(capture), .test(test), .d(d), .sin(sin), .sys_mst(mst),
    .up_a(upset[1]), .up_b(upset[0]), .sca(sca), .scb(scb)
  );

  rsr_merge u_merge (
    .clk(clk), .rst(rst), .test(test), .copy_sys(slv), .copy_scan(scb), .q(q)
  );

  always_comb st = '{mst: mst, slv: slv, sca: sca, scb: scb};
endmodule

// File: rtl/rsr_chain.sv
module rsr_chain
  import rsr_pkg::*;
#(
  parameter int N_CELLS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fclk,
  input  logic               scan_a,
  input  logic               scan_b,
  input  logic               update,
  input  logic               capture,
  input  logic               test,
  input  logic [N_CELLS-1:0] d,
  input  logic               si,
  input  logic [N_CELLS-1:0] upset_m,
  input  logic [N_CELLS-1:0] upset_s,
  input  logic [N_CELLS-1:0] upset_a,
  input  logic [N_CELLS-1:0] upset_b,
  output logic [N_CELLS-1:0] q,
  output logic               so
);
  localparam int LAST = N_CELLS - 1;

  rsr_state_t         st [N_CELLS];
  logic [N_CELLS-1:0] mst_v, slv_v, sca_v, scb_v, sin_v;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign sin_v[i] = si;
    end else begin : g_link
      assign sin_v[i] = scb_v[i-1];
    end

    rsr_cell u_cell (
      .clk(clk), .rst(rst), .fclk(fclk), .scan_a(scan_a), .scan_b(scan_b),
      .update(update), .capture(capture), .test(test), .d(d[i]),
      .sin(sin_v[i]),
      .upset({upset_m[i], upset_s[i], upset_a[i], upset_b[i]}),
      .q(q[i]), .st(st[i])
    );

    assign mst_v[i] = st[i].mst;
    assign slv_v[i] = st[i].slv;
    assign sca_v[i] = st[i].sca;
    assign scb_v[i] = st[i].scb;
  end

  assign so = scb_v[LAST];
endmodule

// File: rtl/rsr_chain_chk.sv
module rsr_chain_chk #(
  parameter int N_CELLS = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               scan_a,
  input logic               capture,
  input logic               update,
  input logic               test,
  input logic [N_CELLS-1:0] q,
  input logic [N_CELLS-1:0] mst_v,
  input logic [N_CELLS-1:0] slv_v,
  input logic [N_CELLS-1:0] sca_v,
  input logic [N_CELLS-1:0] scb_v,
  input logic [N_CELLS-1:0] sin_v,
  input logic [N_CELLS-1:0] upset_m,
  input logic [N_CELLS-1:0] upset_a
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
    p_agree_pass_r2: assert property (@(posedge clk) disable iff (rst)
      (!test && slv_v[i] == scb_v[i]) |=> (q[i] == $past(slv_v[i])));

    p_mismatch_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!test && slv_v[i] != scb_v[i]) |=> $stable(q[i]));

    p_test_sys_only_r5: assert property (@(posedge clk) disable iff (rst)
      test |=> (q[i] == $past(slv_v[i])));

    p_shift_load_r6: assert property (@(posedge clk) disable iff (rst)
      (scan_a && !upset_a[i]) |=> (sca_v[i] == $past(sin_v[i])));

    p_update_load_r7: assert property (@(posedge clk) disable iff (rst)
      (update && !upset_m[i]) |=> (mst_v[i] == $past(scb_v[i])));

    p_scan_frozen_r9: assert property (@(posedge clk) disable iff (rst)
      (!capture && !scan_a && !upset_a[i]) |=> $stable(sca_v[i]));
  end
endmodule

bind rsr_chain rsr_chain_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk(clk), .rst(rst), .scan_a(scan_a), .capture(capture), .update(update),
  .test(test), .q(q), .mst_v(mst_v), .slv_v(slv_v), .sca_v(sca_v),
  .scb_v(scb_v), .sin_v(sin_v), .upset_m(upset_m), .upset_a(upset_a)
);

// File: tb/sim_rsr_chain.sv
`timescale 1ns/1ps
module sim_rsr_chain;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst, fclk, scan_a, scan_b, update, capture, test, si;
  logic [N-1:0] d, upset_m, upset_s, upset_a, upset_b, q;
  logic so;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rsr_chain #(.N_CELLS(N)) u0 (
    .clk(clk), .rst(rst), .fclk(fclk), .scan_a(scan_a), .scan_b(scan_b),
    .update(update), .capture(capture), .test(test), .d(d), .si(si),
    .upset_m(upset_m), .upset_s(upset_s), .upset_a(upset_a), .upset_b(upset_b),
    .q(q), .so(so)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic normal_mode();
    test = 0; capture = 1; scan_a = 0; scan_b = 0; update = 0;
  endtask

  task automatic capture_cycle(input logic [N-1:0] val);
    d = val; fclk = 1; tick(1);
    fclk = 0; tick(2);
  endtask

  task automatic shift_step(input logic b);
    si = b; scan_a = 1; tick(1);
    scan_a = 0; scan_b = 1; tick(1);
    scan_b = 0;
  endtask

  task automatic t_reset();
    rst = 1; tick(2); rst = 0; tick(1);
    check("R1 q", q, '0);
    check("R1 so", {{(N-1){1'b0}}, so}, '0);
  endtask

  task automatic t_normal();
    normal_mode(); fclk = 0; tick(1);
    capture_cycle(4'b1010); check("R2 q pattern a", q, 4'b1010);
    capture_cycle(4'b0111); check("R2 q pattern b", q, 4'b0111);
  endtask

  task automatic t_upsets();
    upset_m[1] = 1; tick(1); upset_m = '0;            // R10 flip master of cell 1
    tick(4); check("R3 master upset masked", q, 4'b0111);
    capture_cycle(4'b1100); check("R4 recovery after master upset", q, 4'b1100);
    upset_b[2] = 1; tick(1); upset_b = '0;
    tick(3); check("R3 scan copy upset masked", q, 4'b1100);
    upset_s[3] = 1; tick(1); upset_s = '0;
    tick(2); check("R3 slave upset masked", q, 4'b1100);
    capture_cycle(4'b0011); check("R4 recovery after scan upset", q, 4'b0011);
  endtask

  task automatic t_test_ignores_scan();
    test = 1; capture = 0; tick(1);
    capture_cycle(4'b1001);                               // scan copy still 0011
    check("R5 q from system half only", q, 4'b1001);
    upset_m[0] = 1; tick(1); upset_m = '0; tick(2);
    check("R10 master flip reaches q in test mode", q, 4'b1000);
  endtask

  task automatic t_shift_update();
    logic [N-1:0] pat = 4'b0110;
    fclk = 1; tick(1);
    for (int k = N - 1; k >= 0; k--) shift_step(pat[k]);
    check("R6 so after shift", {{(N-1){1'b0}}, so}, {{(N-1){1'b0}}, pat[N-1]});
    fclk = 0; update = 1; tick(1); update = 0; tick(2);
    check("R7 update loads pattern", q, pat);
  endtask

  task automatic t_capture_out();
    logic [N-1:0] resp = 4'b1011;
    logic [N-1:0] got;
    d = resp; fclk = 1; tick(1);
    fclk = 0; capture = 1; tick(1); capture = 0; tick(1);
    fclk = 1; tick(1);
    for (int k = N - 1; k >= 0; k--) begin
      got[k] = so;
      shift_step(1'b0);
    end
    check("R8 captured response shifted out", got, resp);
  endtask

  task automatic t_economy();
    logic [N-1:0] pat = 4'b1101;
    logic [N-1:0] got;
    fclk = 1; tick(1);
    for (int k = N - 1; k >= 0; k--) shift_step(pat[k]);
    scan_b = 1; tick(1);
    capture_cycle(4'b0101); check("R9 economy q follows d", q, 4'b0101);
    capture_cycle(4'b1010); check("R9 economy q follows d again", q, 4'b1010);
    scan_b = 0; fclk = 1; tick(1);
    for (int k = N - 1; k >= 0; k--) begin
      got[k] = so;
      shift_step(1'b0);
    end
    check("R9 scan contents kept in economy", got, pat);
  endtask

  initial begin
    rst = 1; fclk = 0; scan_a = 0; scan_b = 0; update = 0; capture = 0;
    test = 0; si = 0; d = '0;
    upset_m = '0; upset_s = '0; upset_a = '0; upset_b = '0;
    tick(1);
    t_reset();
    t_normal();
    t_upsets();
    t_test_ignores_scan();
    t_shift_update();
    t_capture_out();
    t_economy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule